// File: doc/BRIEF.md
# Control Word Loader for a Frequency Synthesizer

This block builds a 40-bit synthesizer control word from a narrow data bus and holds a second, active copy of the word that the synthesizer core uses. The word has two parts. One is an 8-bit control byte, which carries a 5-bit phase offset, a power-down flag and a two-bit loading-format field. The other is a 32-bit frequency tuning word. A host fills the staging copy with pulses on a load strobe. A pulse on a commit strobe then moves the staging copy into the active copy in one step and sends the load position back to the start.

The block has two loading formats. In byte mode, five strobed bytes fill the word. In bit mode, forty strobed bits arrive on the top data line. The format in force is the one held in the committed control byte. After reset the block is in byte mode. A host therefore commits a byte-mode word whose format field is `2'b11` to enter bit mode. It commits a bit-mode word with any other format value to return to byte mode. Both strobes are asynchronous to the core clock. They pass through synchronizers and act on their rising edges.

Top module: `ctlw_loader`

## Requirements
- R1: While `rst` is high and on the cycle after it, `tune_word`, `phase_word`, `power_down` and `serial_mode` are all zero (byte mode), and the load position returns to the first slot.
- R2: In byte mode, successive load strobes capture `data_in` into five slots. Slot 1 is the control byte. Slots 2 to 5 are the tuning word, from its bits [31:24] down to bits [7:0].
- R3: After a commit, `phase_word` equals control bits [7:3] and `power_down` equals control bit 2. `serial_mode` is 1 exactly when control bits [1:0] equal `2'b11`.
- R4: The active outputs do not change until a commit strobe. Load strobes alone leave them as they were.
- R5: In bit mode, each load strobe shifts in `data_in[7]` and the other data lines are ignored. The first bit becomes tuning bit 0 and the 32nd becomes tuning bit 31. Bits 33 to 40 become control bits 0 to 7.
- R6: Load strobes after the fifth byte in byte mode, or after the 40th bit in bit mode, leave the staging word unchanged until the next commit.
- R7: A commit returns the load position to the first slot, including after a partial load. Slots that a partial load did not reach keep their earlier staging contents.
- R8: Reset does not clear the staging word. A commit after reset with no loads in between makes active the word that was staged before reset.
- R9: Each strobe passes through a two-flop synchronizer and acts once per rising edge. The active outputs change on the third core clock edge after a commit strobe rises, and not earlier.
- R10: Committing a bit-mode word whose format field is not `2'b11` returns the block to byte mode for the loads that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 8 | Byte bus; bit 7 carries serial data in bit mode |
| load_strobe | input | 1 | Asynchronous load strobe, acts on its rising edge |
| commit_strobe | input | 1 | Asynchronous commit strobe, acts on its rising edge |
| tune_word | output | 32 | Active frequency tuning word |
| phase_word | output | 5 | Active phase offset |
| power_down | output | 1 | Active power-down flag |
| serial_mode | output | 1 | 1 when bit-mode loading is selected |

## Verification
The assertions assume that each strobe stays high and stays low for at least two core clocks, so that every rising edge gives exactly one detected pulse. They also assume that `data_in` is stable from one clock before a load strobe rises until several clocks after it. Finally, they assume that the two strobes never rise in the same synchronized cycle. The bench holds each strobe level for three clocks and changes the data only between strobes. It finishes each load sequence before it raises the commit strobe. The random part chooses among full, partial and overfilled loads in whichever mode is current, with random data.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
  localparam logic [1:0] FMT_BITWISE = 2'b11;
  localparam int         PDOWN_POS   = 2;
  localparam int         FMT_W       = 2;
endpackage

// File: rtl/ctlw_edge_sync.sv
module ctlw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse); // R9
endmodule

// File: rtl/ctlw_assembler.sv
module ctlw_assembler #(
  parameter int DATA_W = 8,
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  input  logic              load_pulse,
  input  logic              commit_pulse,
  input  logic              bit_mode,
  output logic [WORD_W-1:0] staged_word
);
  localparam int SLOTS = WORD_W / DATA_W;
  localparam int POS_W = $clog2(WORD_W + 1);
  localparam logic [POS_W-1:0] SLOT_LIMIT = POS_W'(SLOTS);
  localparam logic [POS_W-1:0] BIT_LIMIT  = POS_W'(WORD_W);

  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  limit;
  logic              take;
  logic [WORD_W-1:0] slot_next;
  logic [WORD_W-1:0] shift_next;

  assign limit      = bit_mode ? BIT_LIMIT : SLOT_LIMIT;
  assign take       = load_pulse && !commit_pulse && !rst && (pos < limit);
  assign shift_next = {data_in[DATA_W-1], staged_word[WORD_W-1:1]};

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam int HI = WORD_W - 1 - g * DATA_W;
    assign slot_next[HI -: DATA_W] =
      (pos == POS_W'(g)) ? data_in : staged_word[HI -: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst)               pos <= '0;
    else if (commit_pulse) pos <= '0;
    else if (take)         pos <= pos + 1'b1;
  end

  // Staging word has no reset so that it survives a master reset.
  always_ff @(posedge clk) begin
    if (take) staged_word <= bit_mode ? shift_next : slot_next;
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
    pos <= limit); // R6
  AST_COMMIT_REWIND: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |=> pos == '0); // R7
  AST_FULL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (pos == limit && !commit_pulse) |=> $stable(staged_word)); // R6
endmodule

// File: rtl/ctlw_active_regs.sv
module ctlw_active_regs #(
  parameter int DATA_W  = 8,
  parameter int TUNE_W  = 32,
  parameter int PHASE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     commit_pulse,
  input  logic [DATA_W+TUNE_W-1:0] staged_word,
  output logic [TUNE_W-1:0]        tune_q,
  output logic [PHASE_W-1:0]       phase_q,
  output logic                     pdown_q,
  output logic                     bit_mode_q
);
  import ctlw_pkg::*;
  localparam int WORD_W = DATA_W + TUNE_W;

  logic [DATA_W-1:0] ctl_byte;
  assign ctl_byte = staged_word[WORD_W-1 -: DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      tune_q     <= '0;
      phase_q    <= '0;
      pdown_q    <= 1'b0;
      bit_mode_q <= 1'b0;
    end else if (commit_pulse) begin
      tune_q     <= staged_word[TUNE_W-1:0];
      phase_q    <= ctl_byte[DATA_W-1 -: PHASE_W];
      pdown_q    <= ctl_byte[PDOWN_POS];
      bit_mode_q <= (ctl_byte[FMT_W-1:0] == FMT_BITWISE);
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (tune_q == '0 && phase_q == '0 && !pdown_q && !bit_mode_q)); // R1
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit_pulse |=> ($stable(tune_q) && $stable(phase_q) && $stable(pdown_q))); // R4
  AST_MODE_FROM_FMT: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |=> bit_mode_q == $past(staged_word[TUNE_W+1:TUNE_W] == FMT_BITWISE)); // R3
endmodule

// File: rtl/ctlw_loader.sv
module ctlw_loader #(
  parameter int DATA_W      = 8,
  parameter int TUNE_W      = 32,
  parameter int PHASE_W     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  data_in,
  input  logic               load_strobe,
  input  logic               commit_strobe,
  output logic [TUNE_W-1:0]  tune_word,
  output logic [PHASE_W-1:0] phase_word,
  output logic               power_down,
  output logic               serial_mode
);
  localparam int WORD_W      = DATA_W + TUNE_W;
  localparam int NUM_STROBES = 2;
  localparam int IDX_LOAD    = 0;
  localparam int IDX_COMMIT  = 1;

  logic [NUM_STROBES-1:0] strobe_raw;
  logic [NUM_STROBES-1:0] strobe_rise;
  logic [WORD_W-1:0]      staged_word;

  assign strobe_raw = {commit_strobe, load_strobe};

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_sync
    ctlw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst        (rst),
      .async_in   (strobe_raw[g]),
      .rise_pulse (strobe_rise[g])
    );
  end

  ctlw_assembler #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_asm (
    .clk          (clk),
    .rst          (rst),
    .data_in      (data_in),
    .load_pulse   (strobe_rise[IDX_LOAD]),
    .commit_pulse (strobe_rise[IDX_COMMIT]),
    .bit_mode     (serial_mode),
    .staged_word  (staged_word)
  );

  ctlw_active_regs #(.DATA_W(DATA_W), .TUNE_W(TUNE_W), .PHASE_W(PHASE_W)) u_act (
    .clk          (clk),
    .rst          (rst),
    .commit_pulse (strobe_rise[IDX_COMMIT]),
    .staged_word  (staged_word),
    .tune_q       (tune_word),
    .phase_q      (phase_word),
    .pdown_q      (power_down),
    .bit_mode_q   (serial_mode)
  );
endmodule

// File: tb/ctlw_loader_tb.sv
module ctlw_loader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  data_in = '0;
  logic        load_strobe = 1'b0;
  logic        commit_strobe = 1'b0;
  logic [31:0] tune_word;
  logic [4:0]  phase_word;
  logic        power_down;
  logic        serial_mode;

  int nvec = 0;
  int nerr = 0;

  logic [39:0] m_stage = '0;
  logic [39:0] m_act = '0;
  int          m_pos = 0;
  bit          m_bit = 1'b0;

  always #10 clk = ~clk;

  ctlw_loader u_dut (
    .clk(clk), .rst(rst), .data_in(data_in),
    .load_strobe(load_strobe), .commit_strobe(commit_strobe),
    .tune_word(tune_word), .phase_word(phase_word),
    .power_down(power_down), .serial_mode(serial_mode)
  );

  function automatic logic [38:0] obs_of(input logic [39:0] w);
    return {w[31:0], w[39:35], w[34], (w[33:32] == 2'b11)};
  endfunction

  function automatic logic [38:0] obs_now();
    return {tune_word, phase_word, power_down, serial_mode};
  endfunction

  task automatic chk(input string tag, input logic [38:0] act, input logic [38:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] d);
    @(negedge clk) data_in = d;
    @(negedge clk) load_strobe = 1'b1;
    repeat (3) @(negedge clk);
    load_strobe = 1'b0;
    repeat (2) @(negedge clk);
    if (m_bit) begin
      if (m_pos < 40) begin m_stage = {d[7], m_stage[39:1]}; m_pos++; end
    end else begin
      if (m_pos < 5) begin m_stage[39 - 8*m_pos -: 8] = d; m_pos++; end
    end
  endtask

  // R9 latency: old value after second edge, new value after third.
  task automatic do_commit(input string tag);
    logic [38:0] old_obs;
    old_obs = obs_of(m_act);
    @(negedge clk) commit_strobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 before third edge", obs_now(), old_obs);
    m_act = m_stage; m_pos = 0; m_bit = (m_stage[33:32] == 2'b11);
    @(negedge clk);
    chk(tag, obs_now(), obs_of(m_act));
    commit_strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_word_bytes(input logic [7:0] ctl, input logic [31:0] tw);
    do_load(ctl);
    for (int i = 0; i < 4; i++) do_load(tw[31 - 8*i -: 8]);
  endtask

  task automatic load_word_bits(input logic [7:0] ctl, input logic [31:0] tw);
    logic [39:0] w;
    w = {ctl, tw};
    for (int i = 0; i < 40; i++) do_load({w[i], 7'($urandom)});
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_act = '0; m_pos = 0; m_bit = 1'b0;
    @(negedge clk);
    chk("R1 reset clears outputs", obs_now(), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 initial reset state", obs_now(), '0);

    // R2, R3: byte mode load, phase 21, power-down set, format 00
    load_word_bytes(8'b10101_1_00, 32'h1234_5678);
    chk("R4 outputs unchanged before commit", obs_now(), '0);
    do_commit("R2 R3 byte-mode word");

    // R3: enter bit mode with format 11
    load_word_bytes(8'b00011_0_11, 32'hDEAD_BEEF);
    do_commit("R3 enter bit mode");
    chk("R3 serial_mode set", {38'd0, serial_mode}, 39'd1);

    // R5, R10: bit-mode word with format 01 returns to byte mode
    load_word_bits(8'b11111_0_01, 32'hA5A5_0F0F);
    chk("R4 outputs unchanged after bit loads", obs_now(), obs_of(m_act));
    do_commit("R5 bit-mode word LSB first");
    chk("R10 back to byte mode", {38'd0, serial_mode}, 39'd0);
    load_word_bytes(8'b00001_0_10, 32'hCAFE_0001);
    do_commit("R10 byte loads after leaving bit mode");

    // R6: overfilled byte loads ignored
    load_word_bytes(8'b01010_0_00, 32'h0BAD_F00D);
    do_load(8'hFF); do_load(8'h77);
    do_commit("R6 extra byte loads ignored");

    // R6 in bit mode: 43 loads
    load_word_bytes(8'b00000_1_11, 32'h0000_0001);
    do_commit("R3 enter bit mode again");
    load_word_bits(8'b10000_1_11, 32'h8000_0003);
    do_load(8'h80); do_load(8'h00); do_load(8'h80);
    do_commit("R6 extra bit loads ignored");
    load_word_bits(8'b00000_0_00, 32'h1357_9BDF);
    do_commit("R10 leave bit mode");

    // R7: partial load then commit, then a full load lands at slot 1
    do_load(8'b11000_0_00); do_load(8'h99);
    do_commit("R7 partial load keeps untouched slots");
    load_word_bytes(8'b00110_1_00, 32'h2468_ACE0);
    do_commit("R7 pointer rewound after commit");

    // R8: staged word survives reset
    load_word_bytes(8'b01111_1_00, 32'hFEDC_BA98);
    do_reset();
    do_commit("R8 staging kept through reset");

    // Random mix
    for (int it = 0; it < 80; it++) begin
      int op;
      int lim;
      int n;
      op  = int'($urandom % 3);
      lim = m_bit ? 40 : 5;
      if (op == 0)      n = lim;
      else if (op == 1) n = 1 + int'($urandom % (lim - 1));
      else              n = lim + 1 + int'($urandom % 3);
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (!m_bit && m_pos == 0 && ($urandom % 2) == 0) d[1:0] = 2'b11;
        do_load(d);
      end
      chk("R4 random hold before commit", obs_now(), obs_of(m_act));
      do_commit(m_bit ? "R5 R6 R7 random bit mode" : "R2 R6 R7 random byte mode");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule